// File: doc/BRIEF.md
# Infrared Pulse Width Capture Receiver

This block times the marks and spaces of a demodulated infrared receiver output. The receiver line is active low: a low level is a mark (carrier present) and a high level is a space (idle). Every edge of the line produces one sample made of a level bit and a duration in microsecond ticks. A falling pin edge closes a space and reports level 0. A rising pin edge closes a mark and reports level 1. A protocol decoder downstream takes the samples one at a time, in the cycle the valid strobe is high.

A prescaler divides the system clock by `CLK_DIV`, so the default of 64 gives one tick per microsecond at 64 MHz. A single saturating tick counter is cleared only when a mark ends. A space is therefore read straight from the counter. A mark is the counter value at its end minus the value saved when it began. When the counter reaches the programmed idle timeout while the line is high, a timeout strobe fires once, and it cannot fire again until the next edge.

The control is a four-state machine:
- `CAP_OFF`: disabled.
- `CAP_SPACE`: the line is high and the timeout is armed.
- `CAP_MARK`: the line is low.
- `CAP_QUIET`: the line is high and the timeout has already fired.

Its transitions are:
- From `CAP_OFF`, it goes to `CAP_SPACE` or `CAP_MARK` according to the synchronised line level once enabled.
- `CAP_SPACE` goes to `CAP_MARK` on a falling edge.
- `CAP_SPACE` goes to `CAP_QUIET` when the timeout is reached.
- `CAP_MARK` goes to `CAP_SPACE` on a rising edge.
- `CAP_QUIET` goes to `CAP_MARK` on a falling edge.
- Any state goes to `CAP_OFF` when enable is low.

Top module: `ir_pulse_capture`

## Requirements
- R1: After reset, `sample_valid`, `timeout_pulse`, `sample_level` and `sample_dur` are all 0.
- R2: A falling pin edge gives a sample with `sample_level` = 0 (space). A rising pin edge gives a sample with `sample_level` = 1 (mark).
- R3: Durations are counted in ticks, and one tick occurs every `CLK_DIV` clock cycles while the block is enabled.
- R4: A space sample reports the number of ticks since the rising edge that closed the previous mark. The counter is cleared only by that rising edge.
- R5: A mark sample reports the tick count at its rising edge minus the count saved at its falling edge. This equals the number of ticks the mark lasted.
- R6: The counter saturates at `CNT_MAX`, so no reported duration exceeds `CNT_MAX`. A space longer than `CNT_MAX` ticks reports exactly `CNT_MAX`.
- R7: `timeout_pulse` fires when the ticks since the last rising edge reach `timeout_us`, and only while the line is high. It comes between (`timeout_us`-1)·`CLK_DIV`+1 and `timeout_us`·`CLK_DIV` cycles after the mark sample.
- R8: At most one timeout fires per idle period. No timeout fires during a mark, however long the mark is.
- R9: Both strobes are one clock wide, and `sample_valid` and `timeout_pulse` are never high in the same cycle.
- R10: While `enable` is low, the counter, the saved capture, `sample_dur` and both strobes are held at 0, and pin edges produce no sample. Capture resumes after re-enabling.
- R11: The pin passes through a two-flop synchroniser. `sample_valid` rises after the third clock edge that follows the pin change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Capture enable; low holds the block cleared |
| rx_n | input | 1 | Receiver line, low = mark |
| timeout_us | input | CNT_W | Idle timeout in ticks |
| sample_valid | output | 1 | One-cycle strobe for a new sample |
| sample_level | output | 1 | 1 = mark, 0 = space |
| sample_dur | output | CNT_W | Duration of the sample in ticks |
| timeout_pulse | output | 1 | One-cycle idle timeout strobe |

## Verification
A wrong saved capture or a missed counter clear appears at the very next edge as a duration that is off by whole ticks. The bench checks each duration against the exact tick count it drove. A state machine stuck in the wrong state shows up in three ways: a timeout during a mark, a repeated timeout in one idle period, or a timeout that never arrives. Each of these is visible within one timeout window of the rising edge. Logic that keeps running while disabled is caught in the first cycle after `enable` falls, through a non-zero duration or a strobe.

// File: rtl/ir_cap_pkg.sv
package ir_cap_pkg;
    typedef enum logic [1:0] {
        CAP_OFF   = 2'd0,
        CAP_SPACE = 2'd1,
        CAP_MARK  = 2'd2,
        CAP_QUIET = 2'd3
    } cap_state_t;
endpackage

// File: rtl/ir_sync_edge.sv
// Two-flop synchroniser followed by edge detection on the synchronised level (R11).
module ir_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] shift_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            shift_q <= {shift_q[STAGES-2:0], din};
            prev_q  <= shift_q[STAGES-1];
        end
    end

    assign lvl  = shift_q[STAGES-1];
    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;
endmodule

// File: rtl/ir_tick_div.sv
// Prescaler: one tick every CLK_DIV cycles while running (R3).
module ir_tick_div #(
    parameter int CLK_DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int DIV_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(CLK_DIV - 1);

    logic [DIV_W-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase_q <= '0;
        else if (!run || phase_q == LAST)
            phase_q <= '0;
        else
            phase_q <= phase_q + 1'b1;
    end

    assign tick = run && (phase_q == LAST);
endmodule

// File: rtl/ir_dur_counter.sv
// Saturating tick counter. cnt_nxt includes the tick of the current cycle (R6).
module ir_dur_counter #(
    parameter int CNT_W   = 32,
    parameter int CNT_MAX = 32'h7FFF_FFFE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt_nxt
);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(CNT_MAX);

    logic [CNT_W-1:0] cnt_q;

    assign cnt_nxt = (tick && cnt_q < LIM) ? cnt_q + 1'b1 : cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || clr)
            cnt_q <= '0;
        else
            cnt_q <= cnt_nxt;
    end
endmodule

// File: rtl/ir_pulse_capture.sv
module ir_pulse_capture
    import ir_cap_pkg::*;
#(
    parameter int CLK_DIV = 64,
    parameter int CNT_W   = 32,
    parameter int CNT_MAX = 32'h7FFF_FFFE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             rx_n,
    input  logic [CNT_W-1:0] timeout_us,
    output logic             sample_valid,
    output logic             sample_level,
    output logic [CNT_W-1:0] sample_dur,
    output logic             timeout_pulse
);
    logic             sync_lvl;
    logic             rise_ev;
    logic             fall_ev;
    logic             tick;
    logic             clr_cnt;
    logic             at_limit;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] space_cap;
    cap_state_t       state;
    cap_state_t       state_nxt;

    ir_sync_edge #(.STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_n),
        .lvl  (sync_lvl),
        .rise (rise_ev),
        .fall (fall_ev)
    );

    ir_tick_div #(.CLK_DIV(CLK_DIV)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (enable),
        .tick (tick)
    );

    // Cleared only when a mark ends (R4).
    assign clr_cnt  = (state == CAP_MARK) && rise_ev;
    assign at_limit = (cnt_nxt >= timeout_us);

    ir_dur_counter #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (enable),
        .tick   (tick),
        .clr    (clr_cnt),
        .cnt_nxt(cnt_nxt)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= CAP_OFF;
        else
            state <= state_nxt;
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        if (!enable) begin
            state_nxt = CAP_OFF;
        end else begin
            unique case (state)
                CAP_OFF:   state_nxt = sync_lvl ? CAP_SPACE : CAP_MARK;
                CAP_SPACE: begin
                    if (fall_ev)
                        state_nxt = CAP_MARK;
                    else if (sync_lvl && at_limit)
                        state_nxt = CAP_QUIET;
                end
                CAP_MARK:  if (rise_ev) state_nxt = CAP_SPACE;
                CAP_QUIET: if (fall_ev) state_nxt = CAP_MARK;
                default:   state_nxt = CAP_OFF;
            endcase
        end
    end

    // Registered outputs and saved space capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample_valid  <= 1'b0;
            sample_level  <= 1'b0;
            sample_dur    <= '0;
            timeout_pulse <= 1'b0;
            space_cap     <= '0;
        end else if (!enable) begin
            sample_valid  <= 1'b0;
            sample_level  <= 1'b0;
            sample_dur    <= '0;
            timeout_pulse <= 1'b0;
            space_cap     <= '0;
        end else begin
            sample_valid  <= 1'b0;
            timeout_pulse <= 1'b0;
            unique case (state)
                CAP_SPACE, CAP_QUIET: begin
                    if (fall_ev) begin
                        sample_valid <= 1'b1;
                        sample_level <= 1'b0;
                        sample_dur   <= cnt_nxt;
                        space_cap    <= cnt_nxt;
                    end else if (state == CAP_SPACE && sync_lvl && at_limit) begin
                        timeout_pulse <= 1'b1;
                    end
                end
                CAP_MARK: begin
                    if (rise_ev) begin
                        sample_valid <= 1'b1;
                        sample_level <= 1'b1;
                        sample_dur   <= cnt_nxt - space_cap;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ir_pulse_capture_chk.sv
module ir_pulse_capture_chk #(
    parameter int CNT_W   = 32,
    parameter int CNT_MAX = 32'h7FFF_FFFE
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             rise_ev,
    input logic             sync_lvl,
    input logic             sample_valid,
    input logic             sample_level,
    input logic [CNT_W-1:0] sample_dur,
    input logic             timeout_pulse
);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(CNT_MAX);

    assert_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> (sample_level == $past(rise_ev)));

    assert_dur_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> (sample_dur <= LIM));

    assert_idle_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |-> $past(sync_lvl));

    assert_single_timeout_R8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |=> !timeout_pulse);

    assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_valid && timeout_pulse));

    assert_disabled_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!sample_valid && !timeout_pulse && sample_dur == '0));
endmodule

bind ir_pulse_capture ir_pulse_capture_chk #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .rise_ev      (rise_ev),
    .sync_lvl     (sync_lvl),
    .sample_valid (sample_valid),
    .sample_level (sample_level),
    .sample_dur   (sample_dur),
    .timeout_pulse(timeout_pulse)
);

// File: tb/ir_pulse_capture_tb.sv
`timescale 1ns/1ps
module ir_pulse_capture_tb;
    localparam int DIV  = 4;
    localparam int W    = 16;
    localparam int MAXC = 1000;
    localparam int NV   = 5;
    // vector table: mark ticks, space ticks (expected durations equal the stimulus)
    localparam int VMARK [NV] = '{3, 10, 1, 7, 20};
    localparam int VSPACE[NV] = '{5, 2, 1, 12, 4};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enable = 1'b0;
    logic         rx_n = 1'b1;
    logic [W-1:0] timeout_us = 16'd40;
    logic         sample_valid, sample_level, timeout_pulse;
    logic [W-1:0] sample_dur;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int n_smp = 0;
    int n_to = 0;
    int to_cyc = 0;
    int dbl = 0;
    int both = 0;
    int drv_cyc = 0;
    int smp_lvl[64];
    int smp_dur[64];
    int smp_cyc[64];
    logic prev_valid = 1'b0;
    logic prev_to = 1'b0;

    ir_pulse_capture #(.CLK_DIV(DIV), .CNT_W(W), .CNT_MAX(MAXC)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .rx_n         (rx_n),
        .timeout_us   (timeout_us),
        .sample_valid (sample_valid),
        .sample_level (sample_level),
        .sample_dur   (sample_dur),
        .timeout_pulse(timeout_pulse)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (sample_valid && n_smp < 64) begin
            smp_lvl[n_smp] = int'(sample_level);
            smp_dur[n_smp] = int'(sample_dur);
            smp_cyc[n_smp] = cyc;
            n_smp = n_smp + 1;
        end
        if (timeout_pulse) begin
            n_to   = n_to + 1;
            to_cyc = cyc;
        end
        if ((sample_valid && prev_valid) || (timeout_pulse && prev_to)) dbl = dbl + 1;
        if (sample_valid && timeout_pulse) both = both + 1;
        prev_valid = sample_valid;
        prev_to    = timeout_pulse;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_rx(input logic v);
        @(posedge clk);
        #1 rx_n = v;
        drv_cyc = cyc;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        int base;
        int r_cyc;
        int d;
        // R1: reset state
        wait_cyc(3);
        #1;
        chk(sample_valid == 0 && timeout_pulse == 0, "R1 strobes", int'(sample_valid) + int'(timeout_pulse), 0);
        chk(sample_dur == 0 && sample_level == 0, "R1 sample", int'(sample_dur), 0);
        rst_n = 1'b1;
        wait_cyc(2);
        #1 enable = 1'b1;
        wait_cyc(20);

        // vector table walk
        set_rx(1'b0);            // first space, length not checked
        base = n_smp + 1;
        for (int i = 0; i < NV; i++) begin
            wait_cyc(VMARK[i] * DIV - 1);
            set_rx(1'b1);
            wait_cyc(VSPACE[i] * DIV - 1);
            set_rx(1'b0);
        end
        wait_cyc(10);
        chk(n_smp == base + 2 * NV, "R2 sample count", n_smp, base + 2 * NV);
        for (int i = 0; i < NV; i++) begin
            chk(smp_lvl[base + 2*i] == 1, "R2 mark level", smp_lvl[base + 2*i], 1);
            chk(smp_dur[base + 2*i] == VMARK[i], "R5 R3 mark duration", smp_dur[base + 2*i], VMARK[i]);
            chk(smp_lvl[base + 2*i + 1] == 0, "R2 space level", smp_lvl[base + 2*i + 1], 0);
            chk(smp_dur[base + 2*i + 1] == VSPACE[i], "R4 R3 space duration", smp_dur[base + 2*i + 1], VSPACE[i]);
        end
        chk(smp_cyc[n_smp - 1] - drv_cyc == 3, "R11 latency", smp_cyc[n_smp - 1] - drv_cyc, 3);
        chk(n_to == 0, "R7 no timeout on short spaces", n_to, 0);

        // long mark: no timeout, duration still exact
        wait_cyc(100 * DIV - 11);
        chk(n_to == 0, "R8 no timeout during mark", n_to, 0);
        set_rx(1'b1);
        wait_cyc(5);
        chk(smp_lvl[n_smp - 1] == 1 && smp_dur[n_smp - 1] == 100, "R5 long mark", smp_dur[n_smp - 1], 100);
        r_cyc = smp_cyc[n_smp - 1];

        // idle timeout, fired once
        wait_cyc(3 * 40 * DIV);
        chk(n_to == 1, "R8 single timeout", n_to, 1);
        d = to_cyc - r_cyc;
        chk(d > 39 * DIV && d <= 40 * DIV, "R7 timeout position", d, 40 * DIV);

        // saturation of a long space
        wait_cyc(4200);
        set_rx(1'b0);
        wait_cyc(6);
        chk(smp_lvl[n_smp - 1] == 0 && smp_dur[n_smp - 1] == MAXC, "R6 saturated space", smp_dur[n_smp - 1], MAXC);
        chk(n_to == 1, "R8 still one timeout", n_to, 1);

        // new timeout value
        #1 timeout_us = 16'd10;
        wait_cyc(5 * DIV - 8);
        set_rx(1'b1);
        wait_cyc(5);
        r_cyc = smp_cyc[n_smp - 1];
        wait_cyc(30 * DIV - 6);
        set_rx(1'b0);
        wait_cyc(6);
        chk(n_to == 2, "R7 second idle timeout", n_to, 2);
        d = to_cyc - r_cyc;
        chk(d > 9 * DIV && d <= 10 * DIV, "R7 programmed timeout", d, 10 * DIV);
        chk(smp_dur[n_smp - 1] == 30, "R4 space after timeout", smp_dur[n_smp - 1], 30);

        // disable: edges ignored, outputs cleared
        wait_cyc(20);
        #1 enable = 1'b0;
        base = n_smp;
        d = n_to;
        wait_cyc(2);
        #1;
        chk(sample_dur == 0 && !sample_valid && !timeout_pulse, "R10 cleared when off", int'(sample_dur), 0);
        set_rx(1'b1);
        wait_cyc(12);
        set_rx(1'b0);
        wait_cyc(12);
        set_rx(1'b1);
        wait_cyc(200);
        chk(n_smp == base, "R10 no samples when off", n_smp - base, 0);
        chk(n_to == d, "R10 no timeout when off", n_to - d, 0);
        #1 enable = 1'b1;
        wait_cyc(8);
        set_rx(1'b0);
        wait_cyc(6 * DIV - 1);
        set_rx(1'b1);
        wait_cyc(6);
        chk(n_smp == base + 2, "R10 capture resumes", n_smp - base, 2);
        chk(smp_lvl[n_smp - 1] == 1 && smp_dur[n_smp - 1] == 6, "R10 R5 mark after re-enable", smp_dur[n_smp - 1], 6);

        chk(dbl == 0, "R9 one-cycle strobes", dbl, 0);
        chk(both == 0, "R9 strobes exclusive", both, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total = total + 1;
        bad = bad + 1;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule